// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and holds each in a status bit. Per-source enables, a master gate and a fixed priority order (lowest index wins) reduce them to a single request line to the processor. A word-addressed register bus with one access per cycle gives software full control. Writes take effect at the clock edge. Reads are combinational from the current register state.

Each source owns a 32-bit vector register, and a mode bit selects fast or normal handling. The vector output always shows the vector of the winning source. When the processor pulses the vector-acknowledge strobe and the winner is in fast mode, the controller clears that source's status bit by itself. After reset the controller is in an injection mode, where software can set status bits directly and hardware lines are ignored. A write-once bit in the master register leaves that mode for good and hands status setting to the real inputs.

Register byte offsets (bits [1:0] of the address are ignored): status 0x000, pending 0x004, enable 0x008, clear 0x00C, mode 0x010, master 0x01C, vectors 0x100 + 4*i.

Top module: `pintc_top`

## Requirements
- R1: After reset, the status, enable, mode and master registers read 0, every vector register reads 0x10, and irqOut is 0.
- R2: While master bit 1 (hardware-live) is 0, a write to the status register sets each status bit written as 1 and leaves the others unchanged, and irqIn has no effect on status.
- R3: Master bit 1 can only be set. Writing 0 to it leaves it at 1, and only reset clears it. Once it is set, writes to the status register have no effect.
- R4: While master bit 1 is 1, a high irqIn bit sets its status bit at the next clock edge. If a clear and a set hit the same bit in one cycle, the set wins.
- R5: Writing the clear register at 0x00C clears every status bit written as 1 and leaves bits written as 0 untouched. Writing all ones clears all bits. A read of 0x00C returns 0.
- R6: The pending register at 0x004 reads status AND enable. A disabled source keeps its status bit, and raises the request again once it is re-enabled.
- R7: irqOut is 1 exactly when master bit 0 is 1 and at least one source is pending. Writing 0 to the master register forces irqOut to 0.
- R8: irqId gives the lowest-indexed pending source, so source 0 has the highest priority.
- R9: The vector register of source i is read and written at 0x100 + 4*i. vecAddr shows the vector of the source named by irqId while irqOut is 1.
- R10: Mode bit i = 1 selects fast mode for source i. A vecAck pulse while irqOut is 1 and the winner is in fast mode clears that winner's status bit at the next edge. For a normal-mode winner, the pulse changes nothing.
- R11: The enable, mode and master registers read back the values written to them, with master bit 0 as the gate and bit 1 as hardware-live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Write strobe for the register bus |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Combinational read data for busAddr |
| irqIn | input | NUM_SRC | Level-sensitive interrupt lines |
| vecAck | input | 1 | Processor vector-acknowledge strobe |
| irqOut | output | 1 | Request to the processor |
| irqId | output | clog2(NUM_SRC) | Index of the winning source |
| vecAddr | output | DATA_W | Vector of the winning source, 0 when none |

## Verification
The properties assume that irqIn, the bus signals and vecAck are synchronous to clk, and that at most one register write occurs per cycle. They also assume vecAck is a single-cycle pulse sampled at the same edge as the bus. The bench drives every input on the falling edge and holds it for whole cycles, so each property samples settled values. It reads results back only through the bus and the vector outputs. Scenarios run in a fixed order: injection-mode checks happen before the hardware-live bit is set, because that bit cannot be undone without a reset.

// File: rtl/pintc_pkg.sv
package pintc_pkg;

  localparam int VecSlotW = 6;

  localparam int OFS_STATUS = 'h000;
  localparam int OFS_PEND   = 'h004;
  localparam int OFS_ENABLE = 'h008;
  localparam int OFS_CLEAR  = 'h00C;
  localparam int OFS_MODE   = 'h010;
  localparam int OFS_MASTER = 'h01C;
  localparam int OFS_VECTOR = 'h100;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_STATUS,
    RD_PEND,
    RD_ENABLE,
    RD_MODE,
    RD_MASTER,
    RD_VECTOR
  } rdSel_t;

  typedef struct packed {
    logic                wrStatus;
    logic                wrEnable;
    logic                wrClear;
    logic                wrMode;
    logic                wrMaster;
    logic                wrVector;
    logic [VecSlotW-1:0] vecIdx;
    logic                autoClr;
    rdSel_t              rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/pintc_prio.sv
module pintc_prio #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] winId
);

  always_comb begin
    found = 1'b0;
    winId = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        winId = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/pintc_ctrl.sv
module pintc_ctrl
  import pintc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 12
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              vecAck,
  input  logic              hwLive,
  input  logic              reqActive,
  input  logic              winFast,
  output ctlStrobes_t       ctl
);

  logic [ADDR_W-1:0] wordAddr;
  logic              vecRegion;
  logic              vecHit;
  logic [VecSlotW-1:0] slot;

  assign wordAddr  = {busAddr[ADDR_W-1:2], 2'b00};
  assign slot      = busAddr[VecSlotW+1:2];
  assign vecRegion = (busAddr[ADDR_W-1:VecSlotW+2] == (ADDR_W-VecSlotW-2)'(OFS_VECTOR >> (VecSlotW + 2)));
  assign vecHit    = vecRegion && (int'(slot) < NUM_SRC);

  always_comb begin
    ctl          = '0;
    ctl.rdSel    = RD_NONE;
    ctl.vecIdx   = slot;
    if (vecHit) begin
      ctl.rdSel    = RD_VECTOR;
      ctl.wrVector = busWrEn;
    end else begin
      case (wordAddr)
        ADDR_W'(OFS_STATUS): begin
          ctl.rdSel    = RD_STATUS;
          ctl.wrStatus = busWrEn && !hwLive;
        end
        ADDR_W'(OFS_PEND):   ctl.rdSel = RD_PEND;
        ADDR_W'(OFS_ENABLE): begin
          ctl.rdSel    = RD_ENABLE;
          ctl.wrEnable = busWrEn;
        end
        ADDR_W'(OFS_CLEAR):  ctl.wrClear = busWrEn;
        ADDR_W'(OFS_MODE): begin
          ctl.rdSel  = RD_MODE;
          ctl.wrMode = busWrEn;
        end
        ADDR_W'(OFS_MASTER): begin
          ctl.rdSel    = RD_MASTER;
          ctl.wrMaster = busWrEn;
        end
        default: ctl.rdSel = RD_NONE;
      endcase
    end
    ctl.autoClr = vecAck && reqActive && winFast;
  end

endmodule

// File: rtl/pintc_dpath.sv
module pintc_dpath
  import pintc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter logic [DATA_W-1:0] DEF_VEC = 'h10,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [DATA_W-1:0]  busWrData,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  busRdData,
  output logic               reqActive,
  output logic               winFast,
  output logic [IDX_W-1:0]   winId,
  output logic [DATA_W-1:0]  vecAddr,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [NUM_SRC-1:0] modeQ,
  output logic               masterEn,
  output logic               hwLive
);

  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] statusNxt;
  logic [NUM_SRC-1:0] winMask;
  logic [NUM_SRC-1:0] wrBits;
  logic               found;
  logic [DATA_W-1:0]  vecTable [NUM_SRC];
  logic [DATA_W-1:0]  vecRead;

  assign wrBits  = busWrData[NUM_SRC-1:0];
  assign pendVec = statusQ & enableQ;
  assign winMask = NUM_SRC'(1) << winId;

  pintc_prio #(.N(NUM_SRC)) prio_i (
    .req   (pendVec),
    .found (found),
    .winId (winId)
  );

  assign reqActive = masterEn && found;
  assign winFast   = modeQ[winId];
  assign vecAddr   = found ? vecTable[winId] : '0;

  // Ordering: software set, then clears, then hardware set (set wins)
  always_comb begin
    statusNxt = statusQ;
    if (ctl.wrStatus) statusNxt = statusNxt | wrBits;
    if (ctl.wrClear)  statusNxt = statusNxt & ~wrBits;
    if (ctl.autoClr)  statusNxt = statusNxt & ~winMask;
    if (hwLive)       statusNxt = statusNxt | irqIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      enableQ  <= '0;
      modeQ    <= '0;
      masterEn <= 1'b0;
      hwLive   <= 1'b0;
    end else begin
      statusQ <= statusNxt;
      if (ctl.wrEnable) enableQ <= wrBits;
      if (ctl.wrMode)   modeQ   <= wrBits;
      if (ctl.wrMaster) begin
        masterEn <= busWrData[0];
        hwLive   <= hwLive | busWrData[1];
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_vec
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) vecTable[i] <= DEF_VEC;
      else if (ctl.wrVector && ctl.vecIdx == VecSlotW'(i)) vecTable[i] <= busWrData;
    end
  end

  always_comb begin
    vecRead = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (ctl.vecIdx == VecSlotW'(i)) vecRead = vecTable[i];
    end
  end

  always_comb begin
    case (ctl.rdSel)
      RD_STATUS: busRdData = DATA_W'(statusQ);
      RD_PEND:   busRdData = DATA_W'(pendVec);
      RD_ENABLE: busRdData = DATA_W'(enableQ);
      RD_MODE:   busRdData = DATA_W'(modeQ);
      RD_MASTER: busRdData = DATA_W'({hwLive, masterEn});
      RD_VECTOR: busRdData = vecRead;
      default:   busRdData = '0;
    endcase
  end

endmodule

// File: rtl/pintc_top.sv
module pintc_top
  import pintc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12,
  parameter logic [DATA_W-1:0] DEF_VEC = 'h10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busWrEn,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic [DATA_W-1:0]          busWrData,
  output logic [DATA_W-1:0]          busRdData,
  input  logic [NUM_SRC-1:0]         irqIn,
  input  logic                       vecAck,
  output logic                       irqOut,
  output logic [$clog2(NUM_SRC)-1:0] irqId,
  output logic [DATA_W-1:0]          vecAddr
);

  ctlStrobes_t        ctl;
  logic               reqActive;
  logic               winFast;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] modeQ;
  logic               masterEn;
  logic               hwLive;

  pintc_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) ctrl_i (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .vecAck    (vecAck),
    .hwLive    (hwLive),
    .reqActive (reqActive),
    .winFast   (winFast),
    .ctl       (ctl)
  );

  pintc_dpath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .DEF_VEC(DEF_VEC)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busWrData (busWrData),
    .irqIn     (irqIn),
    .busRdData (busRdData),
    .reqActive (reqActive),
    .winFast   (winFast),
    .winId     (irqId),
    .vecAddr   (vecAddr),
    .statusQ   (statusQ),
    .enableQ   (enableQ),
    .modeQ     (modeQ),
    .masterEn  (masterEn),
    .hwLive    (hwLive)
  );

  assign irqOut = reqActive;

endmodule

// File: rtl/pintc_chk.sv
module pintc_chk
  import pintc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busWrEn,
  input logic [ADDR_W-1:0]          busAddr,
  input logic [DATA_W-1:0]          busWrData,
  input logic [NUM_SRC-1:0]         irqIn,
  input logic                       vecAck,
  input logic                       irqOut,
  input logic [$clog2(NUM_SRC)-1:0] irqId,
  input logic [NUM_SRC-1:0]         statusQ,
  input logic [NUM_SRC-1:0]         enableQ,
  input logic [NUM_SRC-1:0]         modeQ,
  input logic                       masterEn,
  input logic                       hwLive
);

  logic [ADDR_W-1:0] wa;
  logic statusWr;
  logic clearWr;
  assign wa       = {busAddr[ADDR_W-1:2], 2'b00};
  assign statusWr = busWrEn && (wa == ADDR_W'(OFS_STATUS));
  assign clearWr  = busWrEn && (wa == ADDR_W'(OFS_CLEAR));

  assert_idle_inputs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!hwLive && !statusWr) |=> ((statusQ & ~$past(statusQ)) == '0));

  assert_live_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    hwLive |=> hwLive);

  assert_sw_blocked_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hwLive && statusWr) |=> ((statusQ & ~($past(statusQ) | $past(irqIn))) == '0));

  assert_hw_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    hwLive |=> ((statusQ & $past(irqIn)) == $past(irqIn)));

  assert_clear_bits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && !hwLive) |=> ((statusQ & $past(busWrData[NUM_SRC-1:0])) == '0));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !masterEn |-> !irqOut);

  assert_winner_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (statusQ[irqId] && enableQ[irqId]));

  assert_fast_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (vecAck && irqOut && modeQ[irqId] && !(hwLive && irqIn[irqId]) && !statusWr)
      |=> !statusQ[$past(irqId)]);

endmodule

bind pintc_top pintc_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .irqIn     (irqIn),
  .vecAck    (vecAck),
  .irqOut    (irqOut),
  .irqId     (irqId),
  .statusQ   (statusQ),
  .enableQ   (enableQ),
  .modeQ     (modeQ),
  .masterEn  (masterEn),
  .hwLive    (hwLive)
);

// File: tb/pintc_tb.sv
`timescale 1ns/1ps
module pintc_top_tb_top;

  localparam int NUM_SRC = 32;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWrData = '0;
  logic [DATA_W-1:0] busRdData;
  logic [NUM_SRC-1:0] irqIn = '0;
  logic              vecAck = 1'b0;
  logic              irqOut;
  logic [4:0]        irqId;
  logic [DATA_W-1:0] vecAddr;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #2 clk = ~clk;

  pintc_top dut_i (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .irqIn(irqIn),
    .vecAck(vecAck), .irqOut(irqOut), .irqId(irqId), .vecAddr(vecAddr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(int addr, logic [31:0] data);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = ADDR_W'(addr); busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = ADDR_W'(addr);
    #1 data = busRdData;
  endtask

  task automatic expectReg(string req, int addr, logic [31:0] exp);
    logic [31:0] d;
    busRead(addr, d);
    check(req, d, exp);
  endtask

  task automatic testReset();
    check("R1 irqOut", 32'(irqOut), 0);
    expectReg("R1 status", 'h000, 0);
    expectReg("R1 enable", 'h008, 0);
    expectReg("R1 mode", 'h010, 0);
    expectReg("R1 master", 'h01C, 0);
    expectReg("R1 vector5", 'h114, 'h10);
    expectReg("R1 vector31", 'h17C, 'h10);
  endtask

  task automatic testInject();
    irqIn = 32'h0000_0008;
    repeat (2) @(negedge clk);
    expectReg("R2 hw ignored", 'h000, 0);
    irqIn = '0;
    busWrite('h000, 32'h90);
    expectReg("R2 inject", 'h000, 32'h90);
    busWrite('h000, 32'h1);
    expectReg("R2 inject or", 'h000, 32'h91);
    busWrite('h00C, 32'h10);
    expectReg("R5 clear one", 'h000, 32'h81);
    expectReg("R5 clear read", 'h00C, 0);
    busWrite('h00C, 32'hFFFF_FFFF);
    expectReg("R5 clear all", 'h000, 0);
  endtask

  task automatic testEnable();
    busWrite('h000, 32'h220);
    busWrite('h008, 32'h200);
    expectReg("R11 enable rb", 'h008, 32'h200);
    check("R7 gate off", 32'(irqOut), 0);
    busWrite('h01C, 32'h1);
    expectReg("R11 master rb", 'h01C, 32'h1);
    check("R7 irqOut", 32'(irqOut), 1);
    check("R8 id9", 32'(irqId), 9);
    expectReg("R6 pending", 'h004, 32'h200);
    busWrite('h008, 32'h220);
    check("R8 id5", 32'(irqId), 5);
    busWrite('h008, 32'h0);
    check("R6 disabled out", 32'(irqOut), 0);
    expectReg("R6 status held", 'h000, 32'h220);
    busWrite('h008, 32'h20);
    check("R6 reenabled", 32'(irqOut), 1);
    busWrite('h01C, 32'h0);
    check("R7 master off", 32'(irqOut), 0);
    busWrite('h00C, 32'hFFFF_FFFF);
  endtask

  task automatic testVector();
    busWrite('h114, 32'hA000_0050);
    busWrite('h124, 32'h0000_0B00);
    expectReg("R9 vec5 rb", 'h114, 32'hA000_0050);
    expectReg("R9 vec9 rb", 'h124, 32'h0000_0B00);
    busWrite('h000, 32'h220);
    busWrite('h008, 32'h220);
    busWrite('h010, 32'h20);
    expectReg("R11 mode rb", 'h010, 32'h20);
    busWrite('h01C, 32'h1);
    #1;
    check("R9 vecAddr5", vecAddr, 32'hA000_0050);
    @(negedge clk);
    vecAck = 1'b1;
    #1 check("R10 vec during ack", vecAddr, 32'hA000_0050);
    @(negedge clk);
    vecAck = 1'b0;
    expectReg("R10 fast cleared", 'h000, 32'h200);
    check("R9 vecAddr9", vecAddr, 32'h0000_0B00);
    check("R8 id after", 32'(irqId), 9);
    @(negedge clk);
    vecAck = 1'b1;
    @(negedge clk);
    vecAck = 1'b0;
    expectReg("R10 normal kept", 'h000, 32'h200);
    busWrite('h00C, 32'hFFFF_FFFF);
    check("R7 none pending", 32'(irqOut), 0);
  endtask

  task automatic testHardware();
    busWrite('h01C, 32'h3);
    expectReg("R3 live set", 'h01C, 32'h3);
    busWrite('h01C, 32'h0);
    expectReg("R3 live sticky", 'h01C, 32'h2);
    busWrite('h000, 32'h4);
    expectReg("R3 sw blocked", 'h000, 0);
    @(negedge clk);
    irqIn = 32'h80;
    @(negedge clk);
    #1;
    expectReg("R4 hw latch", 'h000, 32'h80);
    busWrite('h00C, 32'h80);
    expectReg("R4 set wins", 'h000, 32'h80);
    @(negedge clk);
    irqIn = '0;
    busWrite('h00C, 32'h80);
    expectReg("R4 cleared", 'h000, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    failCount++;
    checkCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInject();
    testEnable();
    testVector();
    testHardware();
    finish();
  end

endmodule